// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block keeps the two thresholds used by a FIFO's programmable flags: the empty-side threshold and the full-side threshold. A single configuration pin (`cfg_ld`) does two jobs. While master reset is held, it picks a pair of default threshold values and chooses how the thresholds are loaded afterwards: bit by bit, or a word at a time from the data bus. After reset, the same pin selects the threshold registers instead of FIFO memory for write-port and read-port accesses.

In serial mode, the pin that chooses the timing mode during reset becomes a one-bit data input (`mode_sdi`). Each write-clock edge on which `ser_en` is high shifts one bit of that input into the threshold registers. In parallel mode, write-port cycles with `cfg_ld` high take threshold values from `din`. Read-port cycles with `cfg_ld` high put the stored thresholds on `dout`. During either of these register accesses, the block holds back the enables it passes to the FIFO core. Partial reset restarts the access sequences but keeps the thresholds and the loading method. The FIFO memory and the flag comparators are outside this block.

Top module: `flag_ofs_loader`

## Requirements
- R1: A write-clock edge with `mrst` high and `cfg_ld` low sets both thresholds to `DEF_HI` (1023 by default) and selects parallel loading (`par_mode` = 1).
- R2: A write-clock edge with `mrst` high and `cfg_ld` high sets both thresholds to `DEF_LO` (127 by default) and selects serial loading (`par_mode` = 0).
- R3: In serial mode, each write-clock edge with `ser_en` high stores `mode_sdi` into one threshold bit. The bits are filled least significant first: bit positions 0 to OFS_W-1 of `empty_ofs`, then bit positions 0 to OFS_W-1 of `full_ofs`. After 2*OFS_W bits, the sequence wraps back to bit 0 of `empty_ofs`.
- R4: In parallel mode, each write-clock edge with `cfg_ld` and `wr_en` high stores `din[OFS_W-1:0]`. Upper bus bits are ignored. Successive writes alternate, starting with `empty_ofs` and then `full_ofs`.
- R5: The loading method that was not chosen has no effect. In parallel mode `ser_en` changes no threshold. In serial mode `cfg_ld` with `wr_en` changes no threshold.
- R6: Each read-clock edge with `cfg_ld` and `rd_en` high loads `dout` with a threshold, zero-extended to DATA_W bits. Successive reads alternate, starting with `empty_ofs` and then `full_ofs`. This works in either mode. At all other times `dout` holds its value, except on reset.
- R7: `fifo_wr_en` equals `wr_en` and `fifo_rd_en` equals `rd_en` while `cfg_ld` is low. Both are low while `cfg_ld` is high.
- R8: Partial reset (`prst`) keeps both thresholds and `par_mode`. It clears `dout` and restarts the parallel write order, the read order and the serial bit position at `empty_ofs`.
- R9: When there is no serial shift and no parallel write, both thresholds keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous, active high, held for several cycles of both clocks |
| prst | input | 1 | Partial reset, synchronous, active high |
| cfg_ld | input | 1 | Default and method select during reset; threshold register access afterwards |
| mode_sdi | input | 1 | Serial threshold data bit after reset |
| ser_en | input | 1 | Serial shift enable |
| wr_en | input | 1 | Write-port enable |
| rd_en | input | 1 | Read-port enable |
| din | input | DATA_W | Write data bus |
| dout | output | DATA_W | Threshold read-back register |
| empty_ofs | output | OFS_W | Empty-side threshold to the flag logic |
| full_ofs | output | OFS_W | Full-side threshold to the flag logic |
| par_mode | output | 1 | 1 = parallel loading, 0 = serial loading |
| fifo_wr_en | output | 1 | Write enable passed to FIFO memory |
| fifo_rd_en | output | 1 | Read enable passed to FIFO memory |

## Verification
The bench builds the block with DATA_W = 12 and OFS_W = 10 and keeps the default values 127 and 1023. With these values, the larger default exactly fills the threshold width. A full serial load is 20 bits, so the bench can finish a load, cut one short with a partial reset, and run past the wrap point in a few dozen cycles. Because the bus is two bits wider than the thresholds, it also shows that the upper data bits are dropped on write and read back as zeros.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;
  // Which threshold register an access sequence points at next.
  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_FULL  = 1'b1
  } slot_e;

  function automatic slot_e next_slot(slot_e s);
    return (s == SLOT_EMPTY) ? SLOT_FULL : SLOT_EMPTY;
  endfunction
endpackage

// File: rtl/ofs_store.sv
module ofs_store
  import flag_ofs_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int OFS_W  = 16,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              cfg_ld,
  input  logic              sdi,
  input  logic              ser_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] din,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output logic              par_mode
);
  localparam int SER_LEN = 2 * OFS_W;
  localparam int CNT_W   = $clog2(SER_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SER_LEN - 1);
  localparam logic [OFS_W-1:0] LO_VAL   = OFS_W'(DEF_LO);
  localparam logic [OFS_W-1:0] HI_VAL   = OFS_W'(DEF_HI);

  slot_e            wslot;
  logic [CNT_W-1:0] bit_cnt;
  logic [OFS_W-1:0] e_hit, f_hit;

  // One-hot bit select for the serial shift, one decoder per threshold bit.
  for (genvar i = 0; i < OFS_W; i++) begin : g_hit
    assign e_hit[i] = (bit_cnt == CNT_W'(i));
    assign f_hit[i] = (bit_cnt == CNT_W'(i + OFS_W));
  end

  logic par_wr, ser_sh;
  assign par_wr = par_mode && cfg_ld && wr_en;
  assign ser_sh = !par_mode && ser_en;

  always_ff @(posedge clk) begin
    if (mrst) begin
      par_mode  <= !cfg_ld;
      empty_ofs <= cfg_ld ? LO_VAL : HI_VAL;
      full_ofs  <= cfg_ld ? LO_VAL : HI_VAL;
      wslot     <= SLOT_EMPTY;
      bit_cnt   <= '0;
    end else if (prst) begin
      wslot   <= SLOT_EMPTY;
      bit_cnt <= '0;
    end else begin
      if (par_wr) begin
        if (wslot == SLOT_EMPTY) empty_ofs <= din[OFS_W-1:0];
        else                     full_ofs  <= din[OFS_W-1:0];
        wslot <= next_slot(wslot);
      end
      if (ser_sh) begin
        for (int i = 0; i < OFS_W; i++) begin
          if (e_hit[i]) empty_ofs[i] <= sdi;
          if (f_hit[i]) full_ofs[i]  <= sdi;
        end
        bit_cnt <= (bit_cnt == CNT_LAST) ? '0 : bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
  import flag_ofs_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              cfg_ld,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  empty_ofs,
  input  logic [OFS_W-1:0]  full_ofs,
  output logic [DATA_W-1:0] dout
);
  slot_e rslot;

  always_ff @(posedge clk) begin
    if (mrst || prst) begin
      dout  <= '0;
      rslot <= SLOT_EMPTY;
    end else if (cfg_ld && rd_en) begin
      dout  <= (rslot == SLOT_EMPTY) ? DATA_W'(empty_ofs) : DATA_W'(full_ofs);
      rslot <= next_slot(rslot);
    end
  end
endmodule

// File: rtl/flag_ofs_loader.sv
module flag_ofs_loader #(
  parameter int DATA_W = 18,
  parameter int OFS_W  = 16,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              cfg_ld,
  input  logic              mode_sdi,
  input  logic              ser_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output logic              par_mode,
  output logic              fifo_wr_en,
  output logic              fifo_rd_en
);
  ofs_store #(
    .DATA_W(DATA_W), .OFS_W(OFS_W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
  ) u_store (
    .clk(wr_clk), .mrst(mrst), .prst(prst), .cfg_ld(cfg_ld),
    .sdi(mode_sdi), .ser_en(ser_en), .wr_en(wr_en), .din(din),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs), .par_mode(par_mode)
  );

  ofs_readback #(
    .DATA_W(DATA_W), .OFS_W(OFS_W)
  ) u_rdbk (
    .clk(rd_clk), .mrst(mrst), .prst(prst), .cfg_ld(cfg_ld),
    .rd_en(rd_en), .empty_ofs(empty_ofs), .full_ofs(full_ofs), .dout(dout)
  );

  // Register accesses never reach the FIFO memory or its pointers.
  assign fifo_wr_en = wr_en && !cfg_ld;
  assign fifo_rd_en = rd_en && !cfg_ld;
endmodule

// File: rtl/flag_ofs_loader_chk.sv
module flag_ofs_loader_chk #(
  parameter int DATA_W = 18,
  parameter int OFS_W  = 16,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              mrst,
  input logic              prst,
  input logic              cfg_ld,
  input logic              ser_en,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] dout,
  input logic [OFS_W-1:0]  empty_ofs,
  input logic [OFS_W-1:0]  full_ofs,
  input logic              par_mode,
  input logic              fifo_wr_en,
  input logic              fifo_rd_en
);
  localparam logic [OFS_W-1:0] LO_VAL = OFS_W'(DEF_LO);
  localparam logic [OFS_W-1:0] HI_VAL = OFS_W'(DEF_HI);

  assert_mrst_hi_R1: assert property (@(posedge wr_clk) disable iff (mrst)
    ($fell(mrst) && !$past(cfg_ld)) |->
      (par_mode && empty_ofs == HI_VAL && full_ofs == HI_VAL));

  assert_mrst_lo_R2: assert property (@(posedge wr_clk) disable iff (mrst)
    ($fell(mrst) && $past(cfg_ld)) |->
      (!par_mode && empty_ofs == LO_VAL && full_ofs == LO_VAL));

  assert_serial_ignores_bus_R5: assert property (@(posedge wr_clk) disable iff (mrst)
    (!par_mode && !ser_en) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  assert_dout_hold_R6: assert property (@(posedge rd_clk) disable iff (mrst)
    (!prst && !(cfg_ld && rd_en)) |=> $stable(dout));

  assert_gate_R7: assert property (@(posedge wr_clk) disable iff (mrst)
    cfg_ld |-> (!fifo_wr_en && !fifo_rd_en));

  assert_prst_keeps_R8: assert property (@(posedge wr_clk) disable iff (mrst)
    prst |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(par_mode)));

  assert_idle_hold_R9: assert property (@(posedge wr_clk) disable iff (mrst)
    (!ser_en && !(cfg_ld && wr_en)) |=> ($stable(empty_ofs) && $stable(full_ofs)));
endmodule

bind flag_ofs_loader flag_ofs_loader_chk #(
  .DATA_W(DATA_W), .OFS_W(OFS_W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .prst(prst),
  .cfg_ld(cfg_ld), .ser_en(ser_en), .wr_en(wr_en), .rd_en(rd_en),
  .dout(dout), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
  .par_mode(par_mode), .fifo_wr_en(fifo_wr_en), .fifo_rd_en(fifo_rd_en)
);

// File: tb/flag_ofs_loader_test.sv
module flag_ofs_loader_test;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 12;
  localparam int OFS_W  = 10;

  logic clk = 1'b0;
  logic mrst = 1'b1, prst = 1'b0, cfg_ld = 1'b0, mode_sdi = 1'b0;
  logic ser_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic [OFS_W-1:0]  empty_ofs, full_ofs;
  logic par_mode, fifo_wr_en, fifo_rd_en;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  flag_ofs_loader #(.DATA_W(DATA_W), .OFS_W(OFS_W)) uut (
    .wr_clk(clk), .rd_clk(clk), .mrst(mrst), .prst(prst), .cfg_ld(cfg_ld),
    .mode_sdi(mode_sdi), .ser_en(ser_en), .wr_en(wr_en), .rd_en(rd_en),
    .din(din), .dout(dout), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .par_mode(par_mode), .fifo_wr_en(fifo_wr_en), .fifo_rd_en(fifo_rd_en)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Inputs change at the falling edge; outputs are sampled there as well.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_mrst(logic ld);
    mrst = 1'b1; cfg_ld = ld;
    step(); step();
    mrst = 1'b0; cfg_ld = 1'b0;
  endtask

  task automatic do_prst();
    prst = 1'b1; step(); prst = 1'b0;
  endtask

  task automatic pwrite(logic [DATA_W-1:0] v);
    cfg_ld = 1'b1; wr_en = 1'b1; din = v;
    step();
    cfg_ld = 1'b0; wr_en = 1'b0;
  endtask

  task automatic pread(output logic [DATA_W-1:0] v);
    cfg_ld = 1'b1; rd_en = 1'b1;
    step();
    v = dout;
    cfg_ld = 1'b0; rd_en = 1'b0;
  endtask

  task automatic sbits(logic [2*OFS_W-1:0] bits, int n);
    ser_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      mode_sdi = bits[i];
      step();
    end
    ser_en = 1'b0; mode_sdi = 1'b0;
  endtask

  task automatic t_reset_hi();
    do_mrst(1'b0);
    chk("R1 empty default", int'(empty_ofs), 1023);
    chk("R1 full default", int'(full_ofs), 1023);
    chk("R1 parallel mode", int'(par_mode), 1);
    chk("R8 dout cleared by reset", int'(dout), 0);
  endtask

  task automatic t_gating();
    wr_en = 1'b1; rd_en = 1'b1; cfg_ld = 1'b0; #1;
    chk("R7 wr pass", int'(fifo_wr_en), 1);
    chk("R7 rd pass", int'(fifo_rd_en), 1);
    cfg_ld = 1'b1; #1;
    chk("R7 wr blocked", int'(fifo_wr_en), 0);
    chk("R7 rd blocked", int'(fifo_rd_en), 0);
    cfg_ld = 1'b0; rd_en = 1'b0;
    // wr_en alone (no cfg_ld) must leave thresholds alone
    step(); step();
    wr_en = 1'b0;
    chk("R9 empty kept", int'(empty_ofs), 1023);
    chk("R9 full kept", int'(full_ofs), 1023);
  endtask

  task automatic t_parallel();
    pwrite(12'hF55);
    chk("R4 first write to empty", int'(empty_ofs), 'h355);
    chk("R4 full untouched", int'(full_ofs), 1023);
    pwrite(12'h0AA);
    chk("R4 second write to full", int'(full_ofs), 'h0AA);
    chk("R4 empty kept", int'(empty_ofs), 'h355);
  endtask

  task automatic t_readback();
    logic [DATA_W-1:0] v;
    pread(v);
    chk("R6 read empty first", int'(v), 'h355);
    pread(v);
    chk("R6 read full second", int'(v), 'h0AA);
    step(); step();
    chk("R6 dout holds", int'(dout), 'h0AA);
  endtask

  task automatic t_par_ignores_serial();
    sbits('1, 4);
    chk("R5 empty kept in parallel", int'(empty_ofs), 'h355);
    chk("R5 full kept in parallel", int'(full_ofs), 'h0AA);
  endtask

  task automatic t_prst_par();
    logic [DATA_W-1:0] v;
    pwrite(12'h011);
    do_prst();
    chk("R8 empty kept", int'(empty_ofs), 'h011);
    chk("R8 full kept", int'(full_ofs), 'h0AA);
    chk("R8 mode kept", int'(par_mode), 1);
    chk("R8 dout cleared", int'(dout), 0);
    pwrite(12'h022);
    chk("R8 write order restarted", int'(empty_ofs), 'h022);
    chk("R8 full not written", int'(full_ofs), 'h0AA);
    pread(v);
    do_prst();
    pread(v);
    chk("R8 read order restarted", int'(v), 'h022);
  endtask

  task automatic t_reset_lo();
    do_mrst(1'b1);
    chk("R2 empty default", int'(empty_ofs), 127);
    chk("R2 full default", int'(full_ofs), 127);
    chk("R2 serial mode", int'(par_mode), 0);
  endtask

  task automatic t_serial();
    logic [DATA_W-1:0] v;
    sbits({10'h1A5, 10'h2C3}, 2*OFS_W);
    chk("R3 empty loaded", int'(empty_ofs), 'h2C3);
    chk("R3 full loaded", int'(full_ofs), 'h1A5);
    // wrap: the next bit lands in empty bit 0
    sbits({10'h3FF, 10'h000}, 1);
    chk("R3 wrap to empty bit0", int'(empty_ofs), 'h2C2);
    do_prst();
    sbits({10'h155, 10'h0F0}, 2*OFS_W);
    chk("R8 serial restart empty", int'(empty_ofs), 'h0F0);
    chk("R8 serial restart full", int'(full_ofs), 'h155);
    pwrite(12'h3AB);
    chk("R5 bus write ignored empty", int'(empty_ofs), 'h0F0);
    chk("R5 bus write ignored full", int'(full_ofs), 'h155);
    pread(v);
    pread(v);
    pread(v);
    chk("R6 read in serial mode", int'(v), 'h0F0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_hi();
    t_gating();
    t_parallel();
    t_readback();
    t_par_ignores_serial();
    t_prst_par();
    t_reset_lo();
    t_serial();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule